// File: doc/BRIEF.md
# Receive Buffer with Programmable Flush Timeout

This block sits between a serial byte receiver and a packet-oriented host reader. Incoming bytes are stored in a first-in first-out buffer. The reader is told when to collect them by a one-cycle flush strobe. The strobe fires on one of two events. The first is occupancy climbing to a packet-size threshold. The second is the buffer staying non-empty with no new byte for a programmable number of millisecond ticks. The second event makes sure that a short message never sits in the buffer waiting for a packet that will not fill.

The millisecond tick comes from outside as a one-cycle pulse. The idle limit is held in an 8-bit register inside the block. That register is written through a simple write strobe and resets to 16. The flush decision is made by a three-state controller:

- EMPTY: no data is held and the timer is stopped.
- COUNTING: data is held and the controller counts ticks since the last accepted byte.
- RELEASED: a flush has been requested, and no further request is raised until new data arrives.

The transitions are:

- first-byte: EMPTY to COUNTING.
- expiry: COUNTING to RELEASED.
- threshold: from any state to RELEASED.
- drain: COUNTING or RELEASED to EMPTY, when the buffer empties.
- refill: RELEASED to COUNTING, on a newly accepted byte.

Top module: `rx_flush_buffer`

## Requirements
- R1: Bytes leave in the order they were accepted. While `rd_avail` is 1, `rd_data` shows the oldest held byte. `occupancy` equals the number of bytes held. A read and a write accepted in the same cycle leave `occupancy` unchanged.
- R2: The buffer holds up to DEPTH bytes (default 384). A write presented while `occupancy` equals DEPTH is dropped, and the stored contents and `occupancy` are left unchanged.
- R3: A dropped write sets `overrun` one cycle later. `overrun` then stays 1 until reset.
- R4: After reset, `occupancy`, `rd_avail`, `flush_req` and `overrun` are 0, and the idle limit is 16 ticks.
- R5: The timer runs only while the buffer is non-empty. `flush_req` is high for one cycle after the clock edge that samples the N-th `ms_tick` since the last accepted byte, where N is the idle limit (1 to 255). Ticks on an empty buffer never raise `flush_req`.
- R6: An accepted byte restarts the idle count from zero. This holds even when `ms_tick` is high in the same cycle; in that case the byte wins and the tick is not counted.
- R7: An idle limit programmed as 0 behaves as 1.
- R8: An accepted write that raises `occupancy` from THRESH-1 to THRESH raises `flush_req` in the next cycle, whatever the timer holds.
- R9: After a flush request, no timer flush is raised until another byte is accepted. That byte restarts a full idle count.
- R10: A cycle with `cfg_we` high loads `cfg_wdata` into the idle-limit register. The new value governs the expiry comparison from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| wr_valid | input | 1 | Byte from the serial receiver is present |
| wr_data | input | DATA_W | Received byte |
| rd_en | input | 1 | Reader removes the oldest byte |
| cfg_we | input | 1 | Load the idle-limit register |
| cfg_wdata | input | TMO_W | New idle limit in ticks |
| rd_data | output | DATA_W | Oldest held byte |
| rd_avail | output | 1 | Buffer is non-empty |
| occupancy | output | $clog2(DEPTH+1) | Bytes held |
| flush_req | output | 1 | One-cycle request for the reader to collect data |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with DEPTH 8 and THRESH 6. With these values, the full, dropped-write and threshold cases each take only a handful of writes. A threshold flush can then be followed by a timer flush while the buffer still holds bytes below the full level. Limits of 0, 5, 16 and 200 ticks cover the zero-as-one rule, write-and-tick collisions, the reset value, and a limit long enough that only the threshold can fire.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_COUNTING = 2'd1,
        ST_RELEASED = 2'd2
    } rxfb_state_e;
endpackage

// File: rtl/rxfb_store.sv
module rxfb_store #(
    parameter int DEPTH  = 384,
    parameter int DATA_W = 8,
    parameter int CW     = 9,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic              wr_acc,
    output logic              rd_acc,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic              overrun
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic              full, empty;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign wr_acc  = wr_req && !full;
    assign rd_acc  = rd_req && !empty;
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_acc) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (wr_acc) wr_ptr <= bump(wr_ptr);
            if (rd_acc) rd_ptr <= bump(rd_ptr);
            unique case ({wr_acc, rd_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_req && full) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/rxfb_timeout_reg.sv
module rxfb_timeout_reg #(
    parameter int TMO_W     = 8,
    parameter int RESET_TMO = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [TMO_W-1:0] cfg_wdata,
    output logic [TMO_W-1:0] limit
);
    logic [TMO_W-1:0] raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      raw_q <= TMO_W'(RESET_TMO);
        else if (cfg_we) raw_q <= cfg_wdata;
    end

    // Zero is not a usable limit: promote it to one tick.
    assign limit = (raw_q == '0) ? TMO_W'(1) : raw_q;
endmodule

// File: rtl/rxfb_flush_fsm.sv
module rxfb_flush_fsm
    import rxfb_pkg::*;
#(
    parameter int CW     = 9,
    parameter int TMO_W  = 8,
    parameter int THRESH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             wr_acc,
    input  logic             rd_acc,
    input  logic [CW-1:0]    count,
    input  logic [TMO_W-1:0] limit,
    output logic             flush_req
);
    rxfb_state_e      state_q, state_d;
    logic [TMO_W-1:0] elapsed_q, elapsed_d;
    logic [CW-1:0]    count_next;
    logic             hit_thresh, expire, fire;

    always_comb begin
        count_next = count;
        if (wr_acc && !rd_acc) count_next = count + 1'b1;
        if (rd_acc && !wr_acc) count_next = count - 1'b1;
    end

    assign hit_thresh = wr_acc && !rd_acc && (count_next == CW'(THRESH));
    assign expire     = ms_tick && (elapsed_q >= limit - 1'b1);

    always_comb begin
        state_d   = state_q;
        elapsed_d = elapsed_q;
        fire      = 1'b0;
        if (hit_thresh) begin
            state_d   = ST_RELEASED;
            elapsed_d = '0;
            fire      = 1'b1;
        end else begin
            unique case (state_q)
                ST_EMPTY: begin
                    if (wr_acc) begin
                        state_d   = ST_COUNTING;
                        elapsed_d = '0;
                    end
                end
                ST_COUNTING: begin
                    if (count_next == '0) begin
                        state_d = ST_EMPTY;
                    end else if (wr_acc) begin
                        elapsed_d = '0;
                    end else if (expire) begin
                        state_d   = ST_RELEASED;
                        elapsed_d = '0;
                        fire      = 1'b1;
                    end else if (ms_tick) begin
                        elapsed_d = elapsed_q + 1'b1;
                    end
                end
                ST_RELEASED: begin
                    if (count_next == '0) begin
                        state_d = ST_EMPTY;
                    end else if (wr_acc) begin
                        state_d   = ST_COUNTING;
                        elapsed_d = '0;
                    end
                end
                default: state_d = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_EMPTY;
            elapsed_q <= '0;
        end else begin
            state_q   <= state_d;
            elapsed_q <= elapsed_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flush_req <= 1'b0;
        else        flush_req <= fire;
    end
endmodule

// File: rtl/rx_flush_buffer.sv
module rx_flush_buffer #(
    parameter int DEPTH     = 384,
    parameter int DATA_W    = 8,
    parameter int TMO_W     = 8,
    parameter int RESET_TMO = 16,
    parameter int THRESH    = 64,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              cfg_we,
    input  logic [TMO_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic [CW-1:0]     occupancy,
    output logic              flush_req,
    output logic              overrun
);
    logic             wr_acc, rd_acc;
    logic [TMO_W-1:0] limit;

    rxfb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CW(CW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_req(wr_valid), .wr_data(wr_data), .rd_req(rd_en),
        .wr_acc(wr_acc), .rd_acc(rd_acc), .rd_data(rd_data),
        .count(occupancy), .overrun(overrun)
    );

    rxfb_timeout_reg #(.TMO_W(TMO_W), .RESET_TMO(RESET_TMO)) u_tmo (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .limit(limit)
    );

    rxfb_flush_fsm #(.CW(CW), .TMO_W(TMO_W), .THRESH(THRESH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .wr_acc(wr_acc), .rd_acc(rd_acc), .count(occupancy),
        .limit(limit), .flush_req(flush_req)
    );

    assign rd_avail = (occupancy != '0);
endmodule

// File: rtl/rx_flush_buffer_chk.sv
module rx_flush_buffer_chk #(
    parameter int DEPTH = 384,
    parameter int CW    = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          rd_en,
    input logic [CW-1:0] occupancy,
    input logic          flush_req,
    input logic          overrun
);
    // R2: occupancy never exceeds capacity
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CW'(DEPTH));

    // R2: a write into a full buffer with no read leaves it full
    a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_en && occupancy == CW'(DEPTH)) |=> occupancy == CW'(DEPTH));

    // R3: a dropped write raises the flag
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && occupancy == CW'(DEPTH)) |=> overrun);

    // R3: the flag is sticky
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    // R5: a flush is never requested for an empty buffer
    a_r5_flush_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> occupancy != '0);

    // R1: occupancy moves by at most one per cycle
    a_r1_occ_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (occupancy == $past(occupancy) ||
                  occupancy == $past(occupancy) + 1'b1 ||
                  occupancy == $past(occupancy) - 1'b1));
endmodule

bind rx_flush_buffer rx_flush_buffer_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_en(rd_en),
    .occupancy(occupancy), .flush_req(flush_req), .overrun(overrun)
);

// File: tb/rx_flush_buffer_bench.sv
module rx_flush_buffer_bench;
    localparam int DEPTH  = 8;
    localparam int THRESH = 6;
    localparam int CW     = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ms_tick = 1'b0, wr_valid = 1'b0, rd_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]    wr_data = '0, cfg_wdata = '0;
    logic [7:0]    rd_data;
    logic          rd_avail, flush_req, overrun;
    logic [CW-1:0] occupancy;

    rx_flush_buffer #(.DEPTH(DEPTH), .THRESH(THRESH)) u_rx_flush_buffer (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_en(rd_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .rd_data(rd_data), .rd_avail(rd_avail), .occupancy(occupancy),
        .flush_req(flush_req), .overrun(overrun)
    );

    always #2 clk = ~clk;

    int    checks = 0, errors = 0, cycles = 0, flush_seen = 0;
    string cur_tag = "R4";
    bit    finished = 0;

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    byte unsigned q[$];
    int  m_state = 0, m_el = 0, m_tmo = 16;
    bit  m_flush = 0, m_ovr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); m_state = 0; m_el = 0; m_tmo = 16; m_flush = 0; m_ovr = 0;
        end else begin
            bit wacc, racc;
            int old_n, new_n, lim;
            wacc = wr_valid && (q.size() < DEPTH);
            racc = rd_en && (q.size() > 0);
            if (wr_valid && !wacc) m_ovr = 1;
            old_n = q.size();
            if (racc) void'(q.pop_front());
            if (wacc) q.push_back(wr_data);
            new_n = q.size();
            lim = (m_tmo == 0) ? 1 : m_tmo;
            m_flush = 0;
            if (wacc && new_n == THRESH && old_n != THRESH) begin
                m_flush = 1; m_state = 2; m_el = 0;
            end else if (m_state == 0) begin
                if (new_n > 0) begin m_state = 1; m_el = 0; end
            end else if (m_state == 1) begin
                if (new_n == 0) m_state = 0;
                else if (wacc) m_el = 0;
                else if (ms_tick) begin
                    if (m_el + 1 >= lim) begin m_flush = 1; m_state = 2; m_el = 0; end
                    else m_el++;
                end
            end else begin
                if (new_n == 0) m_state = 0;
                else if (wacc) begin m_state = 1; m_el = 0; end
            end
            if (cfg_we) m_tmo = cfg_wdata;
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check_eq("R1 occupancy", occupancy, q.size());
            check_eq("R1 rd_avail", rd_avail, q.size() > 0);
            if (q.size() > 0) check_eq("R1 rd_data", rd_data, q[0]);
            check_eq("R3 overrun", overrun, m_ovr);
            check_eq({cur_tag, " flush_req"}, flush_req, m_flush);
            if (flush_req) flush_seen++;
        end
    end

    task automatic step(input bit w, input byte unsigned d, input bit r, input bit t);
        wr_valid = w; wr_data = d; rd_en = r; ms_tick = t;
        @(negedge clk);
        wr_valid = 0; rd_en = 0; ms_tick = 0; cfg_we = 0;
    endtask

    task automatic set_tmo(input byte unsigned v);
        cfg_we = 1; cfg_wdata = v;
        step(0, 0, 0, 0);
    endtask

    task automatic drain();
        while (occupancy != 0) step(0, 0, 1, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000 && !finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected below 50000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R4 reset state
        check_eq("R4 occupancy", occupancy, 0);
        check_eq("R4 rd_avail", rd_avail, 0);
        check_eq("R4 flush_req", flush_req, 0);
        check_eq("R4 overrun", overrun, 0);

        // R4/R5: default limit of 16 ticks
        cur_tag = "R5";
        for (int i = 0; i < 3; i++) step(1, 8'h10 + i, 0, 0);
        f0 = flush_seen;
        for (int i = 0; i < 15; i++) step(0, 0, 0, 1);
        check_eq("R4 no flush before 16 ticks", flush_seen - f0, 0);
        step(0, 0, 0, 1);
        check_eq("R4 flush on 16th tick", flush_req, 1);
        for (int i = 0; i < 3; i++) begin
            check_eq("R1 order", rd_data, 8'h10 + i);
            step(0, 0, 1, 0);
        end
        f0 = flush_seen;
        for (int i = 0; i < 20; i++) step(0, 0, 0, 1);
        check_eq("R5 empty ticks ignored", flush_seen - f0, 0);

        // R10/R6: limit 5, restart by write, write+tick collision
        cur_tag = "R6";
        set_tmo(5);
        step(1, 8'h21, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        step(1, 8'h22, 0, 1);
        f0 = flush_seen;
        for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
        check_eq("R6 restart delays flush", flush_seen - f0, 0);
        step(0, 0, 0, 1);
        check_eq("R10 flush after 5 ticks", flush_req, 1);
        drain();

        // R7: zero limit behaves as one
        cur_tag = "R7";
        set_tmo(0);
        step(1, 8'h31, 0, 0);
        step(0, 0, 0, 1);
        check_eq("R7 zero limit flush", flush_req, 1);
        drain();

        // R8/R9: threshold flush, then silence until new byte
        cur_tag = "R8";
        set_tmo(200);
        for (int i = 0; i < THRESH; i++) step(1, 8'h40 + i, 0, 0);
        check_eq("R8 threshold flush", flush_req, 1);
        cur_tag = "R9";
        set_tmo(2);
        f0 = flush_seen;
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1);
        check_eq("R9 no flush after release", flush_seen - f0, 0);
        step(1, 8'h50, 0, 0);
        step(0, 0, 0, 1);
        check_eq("R9 one tick not enough", flush_req, 0);
        step(0, 0, 0, 1);
        check_eq("R9 refill flush", flush_req, 1);
        drain();

        // R2/R3: fill and overrun
        cur_tag = "R8";
        for (int i = 0; i < DEPTH + 2; i++) step(1, 8'h60 + i, 0, 0);
        check_eq("R2 full occupancy", occupancy, DEPTH);
        check_eq("R3 overrun set", overrun, 1);
        for (int i = 0; i < DEPTH; i++) begin
            check_eq("R2 dropped bytes absent", rd_data, 8'h60 + i);
            step(0, 0, 1, 0);
        end
        check_eq("R3 overrun sticky", overrun, 1);

        // R1: simultaneous read and write
        cur_tag = "R1";
        step(1, 8'h71, 0, 0);
        step(1, 8'h72, 0, 0);
        step(1, 8'h73, 1, 0);
        check_eq("R1 occupancy held", occupancy, 2);
        check_eq("R1 head after swap", rd_data, 8'h72);
        drain();

        // R3: reset clears overrun
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_eq("R3 overrun cleared by reset", overrun, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule